// File: doc/BRIEF.md
# I/O Space Region Decoder

This block sorts each incoming request into one of seven I/O-related regions of a 44-bit physical address map. Each request carries an address, a flag that says whether it is a port-space (I/O) access or a memory access, and a flag that says whether the processor is in system management mode. Five regions sit at fixed addresses: the legacy port space, the legacy video window, the interrupt-controller window, the firmware window and the configuration window. The configuration window is placed by a programmable base nibble. Two large memory-mapped windows cover everything above that base.

For each request the block returns a one-hot region code and a 3-bit target index taken from address bits that depend on the region. The index selects an entry in a target list held elsewhere. When no region claims the address, the block raises a miss flag instead. A band of addresses just under 4 GB is kept free for the fixed devices that live there, so no large window may claim it. Configuration and firmware accesses may also arrive through a relocated upper-address alias, but only in management mode. Every region can be turned off with its own enable bit. The result is registered, so it appears one cycle after the request strobe.

Top module: `io_region_decoder`

## Requirements
- R1: `res_valid` is high in exactly the cycle after a cycle with `req_valid` high and low otherwise. The result fields belong to the request sampled at that edge. After reset `res_valid`, `res_region` and `res_miss` are all zero.
- R2: `res_region` is one-hot with bit 0 = legacy port space, 1 = video window, 2 = interrupt-controller window, 3 = firmware window, 4 = configuration window, 5 = lower memory-mapped window, 6 = upper memory-mapped window. With a valid result, `res_miss` is high exactly when `res_region` is zero.
- R3: Memory regions match only when address bits [43:32] are zero. The configuration and firmware regions also match when bits [43:32] equal 0xFF0, but only while `req_smm` is high.
- R4: The configuration window matches when addr[31:28] equals `cfg_base`, and its target is addr[27:25].
- R5: The lower window matches when addr[31:28] > `cfg_base` with addr[31] = 0. The upper window matches when addr[31:28] > `cfg_base` with addr[31] = 1. Both take addr[30:28] as their target.
- R6: When addr[31:26] is all ones (4 GB minus 64 MB up to 4 GB), only the firmware and interrupt-controller windows can match.
- R7: The video window matches when addr[31:17] = 5 (0x000A0000 to 0x000BFFFF), and its target is 0.
- R8: The firmware window matches when addr[31:24] = 0xFF, with target addr[23:21]. The interrupt-controller window matches when addr[31:20] = 0xFEC, with target addr[15:13].
- R9: The legacy port region matches only I/O requests with addr[43:16] zero, and its target is addr[15:13]. No memory region matches an I/O request.
- R10: When several regions match, the one with the lowest bit number in `res_region` wins, together with its target.
- R11: A region whose bit in `region_en` is clear never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 44 | Request address |
| req_is_io | input | 1 | 1 = port-space request, 0 = memory request |
| req_smm | input | 1 | Management mode active |
| cfg_base | input | 4 | Configuration window base, addr[31:28] |
| region_en | input | 7 | Per-region enable, same bit order as `res_region` |
| res_valid | output | 1 | Result valid |
| res_region | output | 7 | One-hot matching region |
| res_target | output | 3 | Target index of the matching region |
| res_miss | output | 1 | No region matched |

## Verification
A wrong match term or a broken priority order shows up at once on the result of the very next request. It appears as a wrong one-hot bit, a wrong target index, or a miss where a hit was due. The result register holds no state beyond one request, so a fault cannot hide across requests. It does surface only for addresses that reach the faulty term, so the stimulus visits each region, each window boundary, the band below 4 GB, the management-mode alias and each overlap between regions.

// File: rtl/io_dec_pkg.sv
package io_dec_pkg;
    localparam int NREG  = 7;
    localparam int TGT_W = 3;

    localparam int REG_PORT  = 0;
    localparam int REG_VGA   = 1;
    localparam int REG_APIC  = 2;
    localparam int REG_FW    = 3;
    localparam int REG_CFG   = 4;
    localparam int REG_MMLO  = 5;
    localparam int REG_MMHI  = 6;

    localparam logic [14:0] VGA_TAG  = 15'd5;
    localparam logic [11:0] APIC_TAG = 12'hFEC;
    localparam logic [7:0]  FW_TAG   = 8'hFF;
    localparam logic [5:0]  HOLE_TAG = 6'h3F;

    typedef struct packed {
        logic             valid;
        logic [NREG-1:0]  region;
        logic [TGT_W-1:0] target;
        logic             miss;
    } dec_res_t;
endpackage

// File: rtl/io_region_match.sv
module io_region_match
    import io_dec_pkg::*;
#(
    parameter int ADDR_W = 44
) (
    input  logic [ADDR_W-1:0]           addr,
    input  logic                        is_io,
    input  logic                        smm,
    input  logic [3:0]                  cfg_base,
    input  logic [NREG-1:0]             region_en,
    output logic [NREG-1:0]             match,
    output logic [NREG-1:0][TGT_W-1:0]  tgt
);
    localparam int HI_W = ADDR_W - 32;
    localparam logic [HI_W-1:0] SYS_HI = HI_W'('hFF0);

    logic [HI_W-1:0] hi;
    logic [31:0]     lo;
    logic            hi_zero, hi_sys, hole, mem, norm_ok, sys_ok;
    logic [NREG-1:0] raw;
    logic            unused_low_bits;

    assign hi = addr[ADDR_W-1:32];
    assign lo = addr[31:0];
    assign unused_low_bits = ^addr[12:0];

    always_comb begin
        hi_zero = (hi == '0);
        hi_sys  = smm && (hi == SYS_HI);
        hole    = (lo[31:26] == HOLE_TAG);
        mem     = !is_io;
        norm_ok = mem && hi_zero && !hole;
        sys_ok  = mem && (hi_zero || hi_sys) && !hole;

        raw           = '0;
        raw[REG_PORT] = is_io && (addr[ADDR_W-1:16] == '0);
        raw[REG_VGA]  = norm_ok && (lo[31:17] == VGA_TAG);
        raw[REG_APIC] = mem && hi_zero && (lo[31:20] == APIC_TAG);
        raw[REG_FW]   = mem && (hi_zero || hi_sys) && (lo[31:24] == FW_TAG);
        raw[REG_CFG]  = sys_ok && (lo[31:28] == cfg_base);
        raw[REG_MMLO] = norm_ok && !lo[31] && (lo[31:28] > cfg_base);
        raw[REG_MMHI] = norm_ok &&  lo[31] && (lo[31:28] > cfg_base);

        match = raw & region_en;

        tgt           = '0;
        tgt[REG_PORT] = lo[15:13];
        tgt[REG_VGA]  = '0;
        tgt[REG_APIC] = lo[15:13];
        tgt[REG_FW]   = lo[23:21];
        tgt[REG_CFG]  = lo[27:25];
        tgt[REG_MMLO] = lo[30:28];
        tgt[REG_MMHI] = lo[30:28];
    end
endmodule

// File: rtl/io_region_pick.sv
module io_region_pick
    import io_dec_pkg::*;
#(
    parameter int N = NREG,
    parameter int W = TGT_W
) (
    input  logic [N-1:0]        match,
    input  logic [N-1:0][W-1:0] tgt,
    output logic [N-1:0]        onehot,
    output logic [W-1:0]        target,
    output logic                none
);
    always_comb begin
        onehot = '0;
        target = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) begin
                onehot    = '0;
                onehot[i] = 1'b1;
                target    = tgt[i];
            end
        end
        none = (match == '0);
    end
endmodule

// File: rtl/io_region_decoder.sv
module io_region_decoder
    import io_dec_pkg::*;
#(
    parameter int ADDR_W = 44
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_is_io,
    input  logic              req_smm,
    input  logic [3:0]        cfg_base,
    input  logic [NREG-1:0]   region_en,
    output logic              res_valid,
    output logic [NREG-1:0]   res_region,
    output logic [TGT_W-1:0]  res_target,
    output logic              res_miss
);
    logic [NREG-1:0]             match;
    logic [NREG-1:0][TGT_W-1:0]  tgt;
    logic [NREG-1:0]             pick_onehot;
    logic [TGT_W-1:0]            pick_target;
    logic                        pick_none;
    dec_res_t                    res_d, res_q;

    io_region_match #(.ADDR_W(ADDR_W)) u_match (
        .addr      (req_addr),
        .is_io     (req_is_io),
        .smm       (req_smm),
        .cfg_base  (cfg_base),
        .region_en (region_en),
        .match     (match),
        .tgt       (tgt)
    );

    io_region_pick #(.N(NREG), .W(TGT_W)) u_pick (
        .match  (match),
        .tgt    (tgt),
        .onehot (pick_onehot),
        .target (pick_target),
        .none   (pick_none)
    );

    always_comb begin
        res_d = '0;
        if (req_valid) begin
            res_d.valid  = 1'b1;
            res_d.region = pick_onehot;
            res_d.target = pick_target;
            res_d.miss   = pick_none;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign res_valid  = res_q.valid;
    assign res_region = res_q.region;
    assign res_target = res_q.target;
    assign res_miss   = res_q.miss;
endmodule

// File: rtl/io_region_decoder_chk.sv
module io_region_decoder_chk
    import io_dec_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_is_io,
    input logic [5:0]      addr_top,
    input logic [NREG-1:0] region_en,
    input logic            res_valid,
    input logic [NREG-1:0] res_region,
    input logic            res_miss
);
    localparam logic [NREG-1:0] MEM_MASK  = ~(NREG'(1) << REG_PORT);
    localparam logic [NREG-1:0] HOLE_MASK = ~((NREG'(1) << REG_FW) | (NREG'(1) << REG_APIC));

    p_strobe_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);
    p_idle_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid);
    p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(res_region));
    p_miss_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_miss == (res_region == '0)));
    p_hole_guard_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_io && addr_top == HOLE_TAG) |=> ((res_region & HOLE_MASK) == '0));
    p_io_only_port_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_is_io) |=> ((res_region & MEM_MASK) == '0));
    p_disabled_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> ((res_region & ~$past(region_en)) == '0));
endmodule

bind io_region_decoder io_region_decoder_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_is_io  (req_is_io),
    .addr_top   (req_addr[31:26]),
    .region_en  (region_en),
    .res_valid  (res_valid),
    .res_region (res_region),
    .res_miss   (res_miss)
);

// File: tb/sim_io_region_decoder.sv
`timescale 1ns/1ps
module sim_io_region_decoder;
    typedef struct packed {
        logic        io;
        logic        smm;
        logic [43:0] addr;
        logic [3:0]  base;
        logic [6:0]  en;
        logic [6:0]  exp_reg;
        logic [2:0]  exp_tgt;
        logic        exp_miss;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 44'h0_0000_2345, 4'h4, 7'h7F, 7'b0000001, 3'd1, 1'b0, 4'd9},  // R9 port hit
        '{1'b1, 1'b0, 44'h0_0001_0000, 4'h4, 7'h7F, 7'b0000000, 3'd0, 1'b1, 4'd9},  // R9 port out of range
        '{1'b0, 1'b0, 44'h0_000A_5000, 4'h4, 7'h7F, 7'b0000010, 3'd0, 1'b0, 4'd7},  // R7 video
        '{1'b0, 1'b0, 44'h0_FEC0_6000, 4'h4, 7'h7F, 7'b0000100, 3'd3, 1'b0, 4'd8},  // R8 intr ctrl
        '{1'b0, 1'b0, 44'h0_FFE0_0000, 4'h4, 7'h7F, 7'b0001000, 3'd7, 1'b0, 4'd8},  // R8 firmware
        '{1'b0, 1'b0, 44'h0_4A00_0000, 4'h4, 7'h7F, 7'b0010000, 3'd5, 1'b0, 4'd4},  // R4 config
        '{1'b0, 1'b0, 44'h0_6000_0000, 4'h4, 7'h7F, 7'b0100000, 3'd6, 1'b0, 4'd5},  // R5 lower window
        '{1'b0, 1'b0, 44'h0_D000_0000, 4'h4, 7'h7F, 7'b1000000, 3'd5, 1'b0, 4'd5},  // R5 upper window
        '{1'b0, 1'b0, 44'h0_FD00_0000, 4'h4, 7'h7F, 7'b0000000, 3'd0, 1'b1, 4'd6},  // R6 hole miss
        '{1'b0, 1'b0, 44'h0_3000_0000, 4'h4, 7'h7F, 7'b0000000, 3'd0, 1'b1, 4'd5},  // R5 below base
        '{1'b0, 1'b0, 44'h1_4000_0000, 4'h4, 7'h7F, 7'b0000000, 3'd0, 1'b1, 4'd3},  // R3 upper bits
        '{1'b0, 1'b1, 44'hFF0_FFC0_0000, 4'h4, 7'h7F, 7'b0001000, 3'd6, 1'b0, 4'd3}, // R3 fw alias smm
        '{1'b0, 1'b0, 44'hFF0_FFC0_0000, 4'h4, 7'h7F, 7'b0000000, 3'd0, 1'b1, 4'd3}, // R3 alias no smm
        '{1'b0, 1'b1, 44'hFF0_4200_0000, 4'h4, 7'h7F, 7'b0010000, 3'd1, 1'b0, 4'd3}, // R3 cfg alias
        '{1'b0, 1'b1, 44'hFF0_6000_0000, 4'h4, 7'h7F, 7'b0000000, 3'd0, 1'b1, 4'd3}, // R3 window no alias
        '{1'b1, 1'b0, 44'h0_FEC0_0000, 4'h4, 7'h7F, 7'b0000000, 3'd0, 1'b1, 4'd9},  // R9 io vs memory
        '{1'b0, 1'b0, 44'h0_0000_1000, 4'h4, 7'h7F, 7'b0000000, 3'd0, 1'b1, 4'd9},  // R9 memory low
        '{1'b0, 1'b0, 44'h0_000A_0000, 4'h0, 7'h7F, 7'b0000010, 3'd0, 1'b0, 4'd10}, // R10 video beats cfg
        '{1'b0, 1'b0, 44'h0_000A_0000, 4'h0, 7'h7D, 7'b0010000, 3'd0, 1'b0, 4'd11}, // R11 video off
        '{1'b0, 1'b0, 44'h0_6000_0000, 4'h4, 7'h5F, 7'b0000000, 3'd0, 1'b1, 4'd11}, // R11 lower off
        '{1'b0, 1'b0, 44'h0_FC00_0000, 4'h4, 7'h7F, 7'b0000000, 3'd0, 1'b1, 4'd6},  // R6 hole edge
        '{1'b0, 1'b0, 44'h0_FBFF_FFFF, 4'h4, 7'h7F, 7'b1000000, 3'd7, 1'b0, 4'd6},  // R6 just below
        '{1'b0, 1'b0, 44'h0_F000_0000, 4'hF, 7'h7F, 7'b0010000, 3'd0, 1'b0, 4'd4}   // R4 top base
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [43:0] req_addr = '0;
    logic        req_is_io = 1'b0;
    logic        req_smm = 1'b0;
    logic [3:0]  cfg_base = 4'h4;
    logic [6:0]  region_en = 7'h7F;
    logic        res_valid;
    logic [6:0]  res_region;
    logic [2:0]  res_target;
    logic        res_miss;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    io_region_decoder u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_is_io(req_is_io), .req_smm(req_smm), .cfg_base(cfg_base),
        .region_en(region_en), .res_valid(res_valid), .res_region(res_region),
        .res_target(res_target), .res_miss(res_miss)
    );

    task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 reset", {res_valid, res_region, res_miss, 3'b0},
              {1'b0, 7'b0, 1'b0, 3'b0});
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle", {11'b0, res_valid}, 12'd0);
        for (int i = 0; i < NV; i++) begin
            req_valid = 1'b1;
            req_is_io = VECS[i].io;
            req_smm   = VECS[i].smm;
            req_addr  = VECS[i].addr;
            cfg_base  = VECS[i].base;
            region_en = VECS[i].en;
            @(negedge clk);
            check($sformatf("R%0d vec %0d", VECS[i].rq, i),
                  {res_valid, res_region, res_target, res_miss},
                  {1'b1, VECS[i].exp_reg, VECS[i].exp_tgt, VECS[i].exp_miss});
        end
        // R1 strobe low: no result next cycle
        req_valid = 1'b0;
        req_addr  = 44'h0_6000_0000;
        @(negedge clk);
        check("R1 no strobe", {11'b0, res_valid}, 12'd0);
        // R2 miss and region clear together on fresh strobe after idle
        req_valid = 1'b1;
        req_is_io = 1'b0;
        req_smm   = 1'b0;
        req_addr  = 44'h0_FEFF_FFFF;
        cfg_base  = 4'h4;
        region_en = 7'h7F;
        @(negedge clk);
        check("R2 miss", {res_valid, res_region, res_miss, 3'b0}, {1'b1, 7'b0, 1'b1, 3'b0});
        // R11 all regions off
        req_addr  = 44'h0_FFE0_0000;
        region_en = 7'h00;
        @(negedge clk);
        check("R11 all off", {res_valid, res_region, res_miss, 3'b0}, {1'b1, 7'b0, 1'b1, 3'b0});
        req_valid = 1'b0;
        @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule